// File: doc/BRIEF.md
# Extended-Format Instruction Address Generator

This block decodes one instruction of a 24-bit accumulator machine with a 1 MB byte-addressed memory. It also produces the 20-bit operand address for that instruction. The caller presents up to four instruction bytes left-aligned in a 32-bit word, together with the instruction's own address and the low 20 bits of the base and index registers, and pulses `start`. The block decides whether the instruction is one, two, three or four bytes long. For the two-byte form it returns the two register numbers. For the three- and four-byte forms it decodes the six flag bits and forms a target address from a displacement or a full address field, an optional base term (base register or next-instruction address) and an optional index term.

The two flag bits at the bottom of the first byte select how the operand is treated. It can be the target address itself (immediate), it can sit at the target address (simple), or the target address can hold a pointer to it (indirect). For indirect operands the block issues one read on its memory port, waits for the word, and returns it as the effective address. When both of those bits are zero, the instruction is read in the older three-byte layout, which has a 15-bit address and an index flag. Results are registered and announced by a one-cycle `done` pulse.

Top module: `xaddr_gen`

## Requirements
- R1: Length is taken from the high nibble of byte 0: nibble C or F gives 1, nibble 9, A or B gives 2. Any other nibble gives 3 when byte 1 bit 4 (e) is 0 and 4 when it is 1, except for the older layout (R10), which is always 3.
- R2: For two-byte instructions r1 = byte1[7:4] and r2 = byte1[3:0]. In every other case both are 0. `opcode` is all of byte 0 for one- and two-byte instructions, and byte 0 with bits 1:0 cleared otherwise. `target` and `eff_addr` are 0 and `op_kind` is 0 (register-only) for one- and two-byte instructions.
- R3: Flags are taken from byte0[1]=n, byte0[0]=i, byte1[7]=x, byte1[6]=b, byte1[5]=p and byte1[4]=e. With b=1 and p=0 the target is base_reg plus the field. The field is the 12-bit displacement {byte1[3:0],byte2} zero-extended when e=0, and the 20-bit field {byte1[3:0],byte2,byte3} when e=1.
- R4: With b=0 and p=1 the target is the field plus (pc + length). A 12-bit displacement is sign-extended from its bit 11.
- R5: With b=0 and p=0 the field alone (zero-extended displacement or 20-bit field) is the target.
- R6: When x=1, index_reg is added to the target. All address sums wrap modulo 2^20.
- R7: n=0, i=1 reports op_kind 1 (immediate) with eff_addr equal to target, and no memory read is made.
- R8: n=1, i=1 reports op_kind 2 (simple) with eff_addr equal to target, and no memory read is made.
- R9: n=1, i=0 reports op_kind 3 (indirect). Exactly one read is made with mem_addr = target, mem_rd_en is high one cycle after start is sampled, and eff_addr is the returned mem_rdata. done rises three cycles after the sampling edge.
- R10: n=0, i=0 selects the older layout. The target is the 15-bit field {byte1[6:0],byte2}, plus index_reg when byte1[7]=1. The block reports legacy=1, op_kind 2, length 3, and never reports illegal.
- R11: b=1 together with p=1 (outside the older layout) reports illegal=1. No base term is added, no memory read is made, and eff_addr equals target.
- R12: Without an indirect read, done is high for one cycle, one cycle after start is sampled. A start pulse while an instruction is still in progress is ignored.
- R13: After reset, done and mem_rd_en are 0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding the presented instruction |
| instr | input | 32 | Instruction bytes, byte 0 in bits 31:24 |
| pc | input | 20 | Address of the instruction's first byte |
| base_reg | input | 20 | Base register, address bits |
| index_reg | input | 20 | Index register, address bits |
| mem_rd_en | output | 1 | Pointer read request, one cycle |
| mem_addr | output | 20 | Pointer read address |
| mem_rdata | input | 20 | Pointer word, valid the cycle after the request |
| done | output | 1 | Results valid pulse |
| len | output | 3 | Instruction length in bytes |
| opcode | output | 8 | Opcode byte |
| r1 | output | 4 | First register number (two-byte form) |
| r2 | output | 4 | Second register number (two-byte form) |
| op_kind | output | 2 | 0 register-only, 1 immediate, 2 simple, 3 indirect |
| legacy | output | 1 | Older 15-bit layout in use |
| illegal | output | 1 | b and p both set |
| target | output | 20 | Computed target address |
| eff_addr | output | 20 | Operand address, or the operand value when immediate |

## Verification
The hardest situations to reach from the ports are a negative PC-relative displacement that crosses below the next-instruction address, and base or index sums that wrap past the top of the 1 MB space. Random words seldom produce these with the needed register values. The stimulus therefore adds directed instructions with an all-ones displacement, and base or index values just below 2^20. A second start pulse is placed during a pending indirect read to show it is dropped. The random part chooses the opcode nibble class first and draws the remaining bits freely, so every length class and flag mix appears in quantity.

// File: rtl/xag_pkg.sv
package xag_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_IMM    = 2'd1,
    KIND_SIMPLE = 2'd2,
    KIND_IND    = 2'd3
  } op_kind_t;

  typedef enum logic [1:0] {
    BASE_NONE = 2'd0,
    BASE_B    = 2'd1,
    BASE_PC   = 2'd2
  } base_sel_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_RD1  = 2'd2,
    ST_RD2  = 2'd3
  } xag_state_t;

  typedef struct packed {
    logic n;
    logic i;
    logic x;
    logic b;
    logic p;
    logic e;
  } xag_flags_t;
endpackage

// File: rtl/xag_decode.sv
module xag_decode
  import xag_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 12,
  parameter int LW = 15,
  parameter logic [15:0] ONE_NIB = 16'h9000,
  parameter logic [15:0] TWO_NIB = 16'h0E00
) (
  input  logic [31:0]   instr,
  output logic [2:0]    len,
  output logic [7:0]    opcode,
  output logic [3:0]    r1,
  output logic [3:0]    r2,
  output op_kind_t      kind,
  output logic          legacy,
  output logic          illegal,
  output logic [AW-1:0] field,
  output base_sel_t     base_sel,
  output logic          use_x
);
  localparam int ZW = AW - DW;
  localparam int LZ = AW - LW;

  logic [7:0] b0, b1, b2, b3;
  logic [3:0] nib;
  xag_flags_t fl;

  assign b0  = instr[31:24];
  assign b1  = instr[23:16];
  assign b2  = instr[15:8];
  assign b3  = instr[7:0];
  assign nib = b0[7:4];
  assign fl  = '{n: b0[1], i: b0[0], x: b1[7], b: b1[6], p: b1[5], e: b1[4]};

  always_comb begin
    len      = 3'd3;
    opcode   = b0;
    r1       = '0;
    r2       = '0;
    kind     = KIND_REG;
    legacy   = 1'b0;
    illegal  = 1'b0;
    field    = '0;
    base_sel = BASE_NONE;
    use_x    = 1'b0;
    if (ONE_NIB[nib]) begin
      len = 3'd1;
    end else if (TWO_NIB[nib]) begin
      len = 3'd2;
      r1  = b1[7:4];
      r2  = b1[3:0];
    end else begin
      opcode = {b0[7:2], 2'b00};
      use_x  = fl.x;
      if (!fl.n && !fl.i) begin
        legacy = 1'b1;
        kind   = KIND_SIMPLE;
        field  = {{LZ{1'b0}}, b1[6:0], b2};
      end else begin
        len = fl.e ? 3'd4 : 3'd3;
        if (fl.n && !fl.i)      kind = KIND_IND;
        else if (!fl.n && fl.i) kind = KIND_IMM;
        else                    kind = KIND_SIMPLE;
        if (fl.b && fl.p)  illegal  = 1'b1;
        else if (fl.b)     base_sel = BASE_B;
        else if (fl.p)     base_sel = BASE_PC;
        if (fl.e)
          field = AW'({b1[3:0], b2, b3});
        else if (base_sel == BASE_PC)
          field = {{ZW{b1[3]}}, b1[3:0], b2};
        else
          field = {{ZW{1'b0}}, b1[3:0], b2};
      end
    end
  end
endmodule

// File: rtl/xag_ta_calc.sv
module xag_ta_calc
  import xag_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic [AW-1:0] field,
  input  base_sel_t     base_sel,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] next_pc,
  input  logic          use_x,
  input  logic [AW-1:0] index_val,
  output logic [AW-1:0] ta
);
  logic [AW-1:0] base_term;
  logic [AW-1:0] index_term;

  always_comb begin
    case (base_sel)
      BASE_B:  base_term = base_val;
      BASE_PC: base_term = next_pc;
      default: base_term = '0;
    endcase
  end

  assign index_term = use_x ? index_val : '0;
  assign ta         = field + base_term + index_term;
endmodule

// File: rtl/xaddr_gen.sv
module xaddr_gen
  import xag_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 12,
  parameter int LW = 15,
  parameter logic [15:0] ONE_NIB = 16'h9000,
  parameter logic [15:0] TWO_NIB = 16'h0E00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [31:0]   instr,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] base_reg,
  input  logic [AW-1:0] index_reg,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [2:0]    len,
  output logic [7:0]    opcode,
  output logic [3:0]    r1,
  output logic [3:0]    r2,
  output logic [1:0]    op_kind,
  output logic          legacy,
  output logic          illegal,
  output logic [AW-1:0] target,
  output logic [AW-1:0] eff_addr
);
  xag_state_t    state;
  logic [31:0]   instr_q;
  logic [AW-1:0] pc_q, b_q, x_q;

  logic [2:0]    d_len;
  logic [7:0]    d_opc;
  logic [3:0]    d_r1, d_r2;
  op_kind_t      d_kind;
  logic          d_leg, d_ill, d_use_x;
  logic [AW-1:0] d_field, d_ta, next_pc;
  base_sel_t     d_bsel;

  xag_decode #(
    .AW(AW), .DW(DW), .LW(LW), .ONE_NIB(ONE_NIB), .TWO_NIB(TWO_NIB)
  ) u_decode (
    .instr(instr_q), .len(d_len), .opcode(d_opc), .r1(d_r1), .r2(d_r2),
    .kind(d_kind), .legacy(d_leg), .illegal(d_ill), .field(d_field),
    .base_sel(d_bsel), .use_x(d_use_x)
  );

  assign next_pc = pc_q + AW'(d_len);

  xag_ta_calc #(.AW(AW)) u_ta (
    .field(d_field), .base_sel(d_bsel), .base_val(b_q), .next_pc(next_pc),
    .use_x(d_use_x), .index_val(x_q), .ta(d_ta)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      instr_q   <= '0;
      pc_q      <= '0;
      b_q       <= '0;
      x_q       <= '0;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      done      <= 1'b0;
      len       <= '0;
      opcode    <= '0;
      r1        <= '0;
      r2        <= '0;
      op_kind   <= '0;
      legacy    <= 1'b0;
      illegal   <= 1'b0;
      target    <= '0;
      eff_addr  <= '0;
    end else begin
      done      <= 1'b0;
      mem_rd_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            instr_q <= instr;
            pc_q    <= pc;
            b_q     <= base_reg;
            x_q     <= index_reg;
            state   <= ST_CALC;
          end
        end
        ST_CALC: begin
          len     <= d_len;
          opcode  <= d_opc;
          r1      <= d_r1;
          r2      <= d_r2;
          op_kind <= d_kind;
          legacy  <= d_leg;
          illegal <= d_ill;
          if (d_kind == KIND_REG) begin
            target   <= '0;
            eff_addr <= '0;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end else if (d_kind == KIND_IND && !d_ill) begin
            target    <= d_ta;
            mem_addr  <= d_ta;
            mem_rd_en <= 1'b1;
            state     <= ST_RD1;
          end else begin
            target   <= d_ta;
            eff_addr <= d_ta;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_RD1: state <= ST_RD2;
        ST_RD2: begin
          eff_addr <= mem_rdata;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xaddr_gen_checker.sv
module xaddr_gen_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          mem_rd_en,
  input logic [2:0]    len,
  input logic [1:0]    op_kind,
  input logic          legacy,
  input logic          illegal,
  input logic [AW-1:0] target,
  input logic [AW-1:0] eff_addr
);
  a_r13_reset_quiet: assert property (@(posedge clk)
    rst |=> (!done && !mem_rd_en));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  a_r9_read_then_done: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> ##1 (done && op_kind == 2'd3));

  a_r8_eff_is_target: assert property (@(posedge clk) disable iff (rst)
    (done && op_kind != 2'd3 && op_kind != 2'd0) |-> eff_addr == target);

  a_r11_illegal_no_ptr: assert property (@(posedge clk) disable iff (rst)
    (done && illegal) |-> eff_addr == target);

  a_r1_len_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (len >= 3'd1 && len <= 3'd4));

  a_r10_legacy_shape: assert property (@(posedge clk) disable iff (rst)
    (done && legacy) |-> (len == 3'd3 && op_kind == 2'd2 && !illegal));
endmodule

bind xaddr_gen xaddr_gen_checker #(.AW(AW)) u_checker (
  .clk(clk), .rst(rst), .done(done), .mem_rd_en(mem_rd_en), .len(len),
  .op_kind(op_kind), .legacy(legacy), .illegal(illegal),
  .target(target), .eff_addr(eff_addr)
);

// File: tb/test_xaddr_gen.sv
module test_xaddr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [31:0]   instr = '0;
  logic [AW-1:0] pc = '0, base_reg = '0, index_reg = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [AW-1:0] mem_rdata = '0;
  logic          done;
  logic [2:0]    len;
  logic [7:0]    opcode;
  logic [3:0]    r1, r2;
  logic [1:0]    op_kind;
  logic          legacy, illegal;
  logic [AW-1:0] target, eff_addr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xaddr_gen i_xaddr_gen (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .pc(pc),
    .base_reg(base_reg), .index_reg(index_reg), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .len(len),
    .opcode(opcode), .r1(r1), .r2(r2), .op_kind(op_kind), .legacy(legacy),
    .illegal(illegal), .target(target), .eff_addr(eff_addr)
  );

  function automatic logic [AW-1:0] mem_word(input logic [AW-1:0] a);
    return a ^ 20'h3C3C3;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= mem_word(mem_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] ins, input logic [AW-1:0] p_pc,
                       input logic [AW-1:0] bb, input logic [AW-1:0] xx,
                       output logic [2:0] e_len, output logic [7:0] e_opc,
                       output logic [3:0] e_r1, output logic [3:0] e_r2,
                       output logic [1:0] e_kind, output logic e_leg,
                       output logic e_ill, output logic [AW-1:0] e_ta,
                       output string e_tag);
    logic [7:0] c0, c1, c2, c3;
    logic n, i, x, b, p, e;
    logic [AW-1:0] fld, bt;
    c0 = ins[31:24]; c1 = ins[23:16]; c2 = ins[15:8]; c3 = ins[7:0];
    n = c0[1]; i = c0[0]; x = c1[7]; b = c1[6]; p = c1[5]; e = c1[4];
    e_r1 = 0; e_r2 = 0; e_leg = 0; e_ill = 0; e_ta = 0; e_tag = "R2";
    e_opc = c0; e_kind = 2'd0;
    if (c0[7:4] == 4'hC || c0[7:4] == 4'hF) begin
      e_len = 3'd1;
    end else if (c0[7:4] >= 4'h9 && c0[7:4] <= 4'hB) begin
      e_len = 3'd2; e_r1 = c1[7:4]; e_r2 = c1[3:0];
    end else begin
      e_opc = {c0[7:2], 2'b00};
      if (!n && !i) begin
        e_len = 3'd3; e_leg = 1; e_kind = 2'd2;
        e_ta = {5'b0, c1[6:0], c2} + (x ? xx : 20'd0);
        e_tag = x ? "R10/R6" : "R10";
      end else begin
        e_len = e ? 3'd4 : 3'd3;
        e_kind = (n && !i) ? 2'd3 : (!n && i) ? 2'd1 : 2'd2;
        if (e) fld = {c1[3:0], c2, c3};
        else if (p && !b) fld = {{8{c1[3]}}, c1[3:0], c2};
        else fld = {8'b0, c1[3:0], c2};
        bt = 0;
        if (b && p) begin e_ill = 1; e_tag = "R11"; end
        else if (b) begin bt = bb; e_tag = "R3"; end
        else if (p) begin bt = p_pc + AW'(e_len); e_tag = "R4"; end
        else e_tag = "R5";
        if (x) e_tag = {e_tag, "/R6"};
        e_ta = fld + bt + (x ? xx : 20'd0);
      end
    end
  endtask

  task automatic run_one(input logic [31:0] ins, input logic [AW-1:0] p_pc,
                         input logic [AW-1:0] bb, input logic [AW-1:0] xx,
                         input bit second_start);
    logic [2:0] e_len; logic [7:0] e_opc; logic [3:0] e_r1, e_r2;
    logic [1:0] e_kind; logic e_leg, e_ill; logic [AW-1:0] e_ta, e_eff;
    string tag, ktag;
    int lat, n_done, n_rd;
    logic [AW-1:0] rd_addr;
    bit do_rd;
    model(ins, p_pc, bb, xx, e_len, e_opc, e_r1, e_r2, e_kind, e_leg, e_ill,
          e_ta, tag);
    do_rd = (e_kind == 2'd3) && !e_ill;
    e_eff = (e_kind == 2'd0) ? 20'd0 : do_rd ? mem_word(e_ta) : e_ta;
    ktag = (e_kind == 2'd1) ? "R7" : (e_kind == 2'd3) ? "R9" :
           (e_kind == 2'd2) ? "R8" : "R2";
    @(negedge clk);
    instr = ins; pc = p_pc; base_reg = bb; index_reg = xx; start = 1'b1;
    lat = 0; n_done = 0; n_rd = 0; rd_addr = 0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 1 && second_start) begin
        start = 1'b1; instr = ~ins; pc = ~p_pc;
      end else start = 1'b0;
      if (mem_rd_en) begin n_rd++; rd_addr = mem_addr; end
      if (done) begin
        n_done++;
        if (n_done == 1) begin
          lat = k;
          chk(len == e_len, "R1 len", len, e_len);
          chk(opcode == e_opc && r1 == e_r1 && r2 == e_r2, "R2 fields",
              {opcode, r1, r2}, {e_opc, e_r1, e_r2});
          chk(target == e_ta, {tag, " target"}, target, e_ta);
          chk(op_kind == e_kind && legacy == e_leg && illegal == e_ill,
              {ktag, "/R10/R11 kind"}, {op_kind, legacy, illegal},
              {e_kind, e_leg, e_ill});
          chk(eff_addr == e_eff, {ktag, " eff_addr"}, eff_addr, e_eff);
        end
      end
    end
    start = 1'b0;
    chk(n_done == 1, "R12 single done", n_done, 1);
    chk(lat == (do_rd ? 4 : 2), "R12/R9 latency", lat, do_rd ? 4 : 2);
    chk(n_rd == (do_rd ? 1 : 0), "R9/R7/R8 read count", n_rd, do_rd ? 1 : 0);
    if (do_rd) chk(rd_addr == e_ta, "R9 read address", rd_addr, e_ta);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] w;
    logic [3:0] nb;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    chk(!done && !mem_rd_en && len == 0 && target == 0 && eff_addr == 0 &&
        op_kind == 0, "R13 reset", {done, mem_rd_en, len, op_kind}, 0);
    // directed corner cases
    run_one(32'h032FFF00, 20'h01000, 20'h0, 20'h0, 0);     // R4 negative disp
    run_one(32'h034FFF00, 20'h0, 20'hFFFFE, 20'h0, 0);     // R3 unsigned, wrap
    run_one(32'h0380FF00, 20'h0, 20'h0, 20'hFFFFF, 0);     // R6 wrap
    run_one(32'h00FFFF00, 20'h0, 20'h0, 20'h00010, 0);     // R10 indexed
    run_one(32'h03612300, 20'h0, 20'h55555, 20'h0, 0);     // R11 illegal
    run_one(32'h0261ABCD, 20'h0, 20'h0, 20'h0, 0);         // R11 indirect illegal
    run_one(32'h0211ABCD, 20'h0, 20'h0, 20'h0, 1);         // R9, R12 busy start
    run_one(32'h01123456, 20'h0, 20'h0, 20'h0, 0);         // R7 format 4
    run_one(32'hB4A50000, 20'h0, 20'h0, 20'h0, 0);         // R2 two-byte
    run_one(32'hC4FFFFFF, 20'h0, 20'h0, 20'h0, 0);         // R1 one-byte
    run_one(32'h03100FFF, 20'h0, 20'h0, 20'h0, 0);         // R5 field, R8
    run_one(32'h033FFF00, 20'hFFFFC, 20'h0, 20'h0, 1);     // R4 e=1 wrap, R12
    for (int t = 0; t < 400; t++) begin
      w = $urandom;
      case ($urandom % 6)
        0: nb = ($urandom % 2) ? 4'hC : 4'hF;
        1: nb = 4'h9 + 4'($urandom % 3);
        default: begin
          nb = 4'($urandom);
          while (nb == 4'hC || nb == 4'hF || (nb >= 4'h9 && nb <= 4'hB))
            nb = 4'($urandom);
        end
      endcase
      w[31:28] = nb;
      run_one(w, 20'($urandom), 20'($urandom), 20'($urandom), ($urandom % 8) == 0);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule